// File: doc/BRIEF.md
# Masked BSSID receive address filter

This block decides whether the receive path should accept, and later acknowledge, a frame based on its BSSID. It holds the station's own 48-bit MAC address and a 48-bit mask. An incoming BSSID is compared with the own address on the mask's set bits only. Bits where the mask is zero are ignored. One comparator can therefore serve several virtual BSSes at once: software clears the mask bits where the served BSSIDs differ from the own address.

Both 48-bit values are loaded through a 32-bit write port. Each value takes two writes: a low word carrying address bytes 0 to 3 and an upper halfword carrying bytes 4 and 5. For each frame the receive logic presents the BSSID with a one-cycle valid strobe. One clock later the block returns a done strobe and an accept flag.

The block also contains a small mask accumulator. It starts at all ones. Each BSSID offered to it clears every bit where that BSSID differs from the own address, which leaves the set of bits common to all served BSSes. The filter accepts any frame that agrees on those bits, including frames from BSSes the station does not serve. This is intended behaviour.

Top module: `bssid_mask_filter`

## Requirements
- R1: After reset the mask holds all ones, the own address holds all zeros, the accumulator output `acc_mask` is all ones, and `frm_done` and `frm_accept` are 0. With these reset values, a frame with BSSID 0 is accepted and any other BSSID is rejected.
- R2: A frame is accepted exactly when (frm_bssid AND mask) equals (mask AND own address). Otherwise it is rejected.
- R3: The register writes are decoded by `reg_addr` as follows:
  - 0 writes own-address bytes 0 to 3 from `reg_wdata[31:0]`.
  - 1 writes own-address bytes 4 and 5 from `reg_wdata[15:0]`.
  - 2 writes mask bytes 0 to 3.
  - 3 writes mask bytes 4 and 5.
  
  Byte k of an address occupies bits [8k+7:8k] of every 48-bit port, so each write is little-endian. An upper-halfword write leaves the low word unchanged, and a low-word write leaves the upper halfword unchanged.
- R4: With an all-ones mask, only a BSSID equal to the own address on all 48 bits is accepted. A single flipped bit causes a reject.
- R5: Frames that agree only on the masked bits are accepted. Take mask 0x000000000002 and own address 0x000000000001. BSSIDs 0x1, 0x4, 0x9 and 0xD are accepted, and BSSID 0x6 is rejected.
- R6: `frm_done` is 1 in exactly the cycle after a cycle with `frm_valid` high, and 0 otherwise. `frm_accept` carries the decision for that frame and is 0 whenever `frm_done` is 0. Back-to-back frames each get their own result.
- R7: A register write takes effect for frames whose valid strobe comes in the cycle after the write or later. A frame presented in the same cycle as a write is judged with the old values.
- R8: `acc_clear` sets `acc_mask` to all ones on the next clock and has priority over `acc_add`. Otherwise, `acc_add` updates `acc_mask` to acc_mask AND NOT(own address XOR acc_bssid) on the next clock. Without either strobe, `acc_mask` holds its value.
- R9: Start from a clear with own address 0x1. Adding BSSIDs 0x4 and then 0x9 yields `acc_mask` = 0xFFFFFFFFFFF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0/1 address low/high, 2/3 mask low/high) |
| reg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Frame BSSID valid strobe |
| frm_bssid | input | 48 | BSSID of the received frame |
| frm_done | output | 1 | Result valid, one cycle after frm_valid |
| frm_accept | output | 1 | Accept decision for the frame |
| acc_clear | input | 1 | Reset the accumulated mask to all ones |
| acc_add | input | 1 | Fold acc_bssid into the accumulated mask |
| acc_bssid | input | 48 | BSSID offered to the accumulator |
| acc_mask | output | 48 | Accumulated mask |

## Verification
The accept flag and done strobe appear on the first rising edge after the valid strobe. The bench therefore drives each frame on a falling edge and compares the outputs on the next falling edge. A register write is visible from the edge that follows it, so the directed R7 case presents a frame in the same cycle as a write and expects the old decision, then presents the frame again one cycle later and expects the new one. The accumulator output is likewise checked on the falling edge after each clear or add strobe.

// File: rtl/bssid_mask_filter.sv
module bssid_mask_filter #(
  parameter int ADDR_BITS = 48,
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [WORD_BITS-1:0] reg_wdata,
  input  logic                 frm_valid,
  input  logic [ADDR_BITS-1:0] frm_bssid,
  output logic                 frm_done,
  output logic                 frm_accept,
  input  logic                 acc_clear,
  input  logic                 acc_add,
  input  logic [ADDR_BITS-1:0] acc_bssid,
  output logic [ADDR_BITS-1:0] acc_mask
);
  localparam int HI_BITS = ADDR_BITS - WORD_BITS;

  logic [ADDR_BITS-1:0] own_q, mask_q, acc_q;
  logic done_q, accept_q;
  logic hit;

  assign hit = (frm_bssid & mask_q) == (mask_q & own_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= '0;
      mask_q <= '1;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: own_q[WORD_BITS-1:0]          <= reg_wdata;
        2'd1: own_q[ADDR_BITS-1:WORD_BITS]  <= reg_wdata[HI_BITS-1:0];
        2'd2: mask_q[WORD_BITS-1:0]         <= reg_wdata;
        default: mask_q[ADDR_BITS-1:WORD_BITS] <= reg_wdata[HI_BITS-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q   <= frm_valid;
      accept_q <= frm_valid && hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || acc_clear) acc_q <= '1;
    else if (acc_add)        acc_q <= acc_q & ~(own_q ^ acc_bssid);
  end

  assign frm_done   = done_q;
  assign frm_accept = accept_q;
  assign acc_mask   = acc_q;
endmodule

// File: rtl/bssid_mask_filter_chk.sv
module bssid_mask_filter_chk #(
  parameter int ADDR_BITS = 48,
  parameter int WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [1:0]           reg_addr,
  input logic [WORD_BITS-1:0] reg_wdata,
  input logic                 frm_valid,
  input logic [ADDR_BITS-1:0] frm_bssid,
  input logic                 frm_done,
  input logic                 frm_accept,
  input logic                 acc_clear,
  input logic                 acc_add,
  input logic [ADDR_BITS-1:0] acc_mask
);
  localparam int HI_BITS = ADDR_BITS - WORD_BITS;
  logic [ADDR_BITS-1:0] sh_own, sh_mask;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_own  <= '0;
      sh_mask <= '1;
      seen    <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (reg_we && reg_addr == 2'd0) sh_own[WORD_BITS-1:0] <= reg_wdata;
      if (reg_we && reg_addr == 2'd1) sh_own[ADDR_BITS-1:WORD_BITS] <= reg_wdata[HI_BITS-1:0];
      if (reg_we && reg_addr == 2'd2) sh_mask[WORD_BITS-1:0] <= reg_wdata;
      if (reg_we && reg_addr == 2'd3) sh_mask[ADDR_BITS-1:WORD_BITS] <= reg_wdata[HI_BITS-1:0];
    end
  end

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (frm_done == $past(frm_valid))); // R6
  AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |-> !frm_accept); // R6
  AST_MASKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> frm_accept == ((($past(frm_bssid) ^ $past(sh_own)) & $past(sh_mask)) == '0)); // R2
  AST_CLEAR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> acc_mask == '1); // R8
  AST_ADD_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_add && !acc_clear) |=> (acc_mask & ~$past(acc_mask)) == '0); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !acc_add && !acc_clear) |=> $stable(acc_mask)); // R8
endmodule

bind bssid_mask_filter bssid_mask_filter_chk #(.ADDR_BITS(ADDR_BITS), .WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .frm_valid(frm_valid), .frm_bssid(frm_bssid), .frm_done(frm_done), .frm_accept(frm_accept),
  .acc_clear(acc_clear), .acc_add(acc_add), .acc_mask(acc_mask));

// File: tb/bssid_mask_filter_tb.sv
module bssid_mask_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic frm_valid = 1'b0;
  logic [47:0] frm_bssid = '0;
  logic frm_done, frm_accept;
  logic acc_clear = 1'b0, acc_add = 1'b0;
  logic [47:0] acc_bssid = '0;
  logic [47:0] acc_mask;

  int n_vec = 0, n_bad = 0;
  logic [47:0] m_own = '0, m_mask = '1, m_acc = '1;
  bit done_flag = 0;

  always #2 clk = ~clk;

  bssid_mask_filter u_dut (.*);

  function automatic bit exp_accept(logic [47:0] b, logic [47:0] own, logic [47:0] msk);
    return (b & msk) == (msk & own);
  endfunction

  function automatic logic [47:0] rand48();
    return {$urandom() & 32'hFFFF, $urandom()};
  endfunction

  task automatic check(string req, logic [47:0] got, logic [47:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    case (a)
      2'd0: m_own[31:0] = d;
      2'd1: m_own[47:32] = d[15:0];
      2'd2: m_mask[31:0] = d;
      default: m_mask[47:32] = d[15:0];
    endcase
  endtask

  task automatic set_regs(logic [47:0] own, logic [47:0] msk);
    wr(2'd0, own[31:0]); wr(2'd1, {16'h0, own[47:32]});
    wr(2'd2, msk[31:0]); wr(2'd3, {16'h0, msk[47:32]});
  endtask

  task automatic frame(string req, logic [47:0] b);
    frm_valid = 1; frm_bssid = b;
    @(negedge clk);
    frm_valid = 0;
    check(req, {47'h0, frm_done}, 48'h1);
    check(req, {47'h0, frm_accept}, {47'h0, exp_accept(b, m_own, m_mask)});
  endtask

  task automatic acc_step(string req, bit clr, bit add, logic [47:0] b);
    acc_clear = clr; acc_add = add; acc_bssid = b;
    @(negedge clk);
    acc_clear = 0; acc_add = 0;
    if (clr) m_acc = '1;
    else if (add) m_acc = m_acc & ~(m_own ^ b);
    check(req, acc_mask, m_acc);
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 done", {47'h0, frm_done}, 48'h0);
    check("R1 accept", {47'h0, frm_accept}, 48'h0);
    check("R1 acc_mask", acc_mask, '1);
    frame("R1 zero bssid", 48'h0);
    frame("R1 nonzero bssid", 48'h0000_0000_0100);
    @(negedge clk);
    check("R6 done idle", {47'h0, frm_done}, 48'h0);

    // R3 layout / R4 exact match
    set_regs(48'h0605_0403_0201, '1);
    frame("R3 R4 exact", 48'h0605_0403_0201);
    frame("R4 flip lsb", 48'h0605_0403_0200);
    frame("R4 flip msb", 48'h8605_0403_0201);
    wr(2'd1, 32'hAAAA_0706);
    frame("R3 high keeps low", 48'h0706_0403_0201);
    frame("R3 high bytes", 48'h0605_0403_0201);

    // R5 false accepts
    set_regs(48'h1, 48'h2);
    frame("R5 0x1", 48'h1);
    frame("R5 0x4", 48'h4);
    frame("R5 0x9", 48'h9);
    frame("R5 0xD", 48'hD);
    frame("R5 0x6", 48'h6);

    // R7 write in same cycle as frame uses old values
    set_regs(48'h0, '1);
    frm_valid = 1; frm_bssid = 48'h5;
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h5;
    @(negedge clk);
    frm_valid = 0; reg_we = 0;
    check("R7 same cycle old", {47'h0, frm_accept}, 48'h0);
    m_own[31:0] = 32'h5;
    frame("R7 next cycle new", 48'h5);

    // R6 back-to-back frames
    for (int i = 0; i < 4; i++) frame("R6 back-to-back", (i % 2) ? 48'h5 : 48'h7);

    // R9 accumulator example, R8 clear priority
    set_regs(48'h1, '1);
    acc_step("R8 clear", 1, 0, '0);
    acc_step("R9 add 0x4", 0, 1, 48'h4);
    acc_step("R9 add 0x9", 0, 1, 48'h9);
    check("R9 value", acc_mask, 48'hFFFF_FFFF_FFF2);
    @(negedge clk);
    check("R8 hold", acc_mask, 48'hFFFF_FFFF_FFF2);
    acc_step("R8 clear wins", 1, 1, 48'h0);

    // random R2 / R8
    for (int r = 0; r < 40; r++) begin
      set_regs(rand48(), rand48() | rand48());
      for (int k = 0; k < 10; k++) begin
        logic [47:0] b;
        b = ($urandom() % 2) ? (m_own ^ (rand48() & ~m_mask)) : rand48();
        frame("R2 random", b);
      end
      acc_step("R8 random clear", 1, 0, '0);
      for (int k = 0; k < 4; k++) begin
        logic [47:0] b;
        b = m_own ^ (rand48() & rand48() & rand48());
        acc_step("R8 random add", 0, 1, b);
      end
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule